// File: doc/BRIEF.md
# Flag Threshold Offset Register File

This block holds the two threshold offsets used by a synchronous FIFO's partial-status flags. One offset sets the almost-empty threshold and the other sets the almost-full threshold. Each offset is as wide as the FIFO address, which is 9 to 13 bits. Software loads the offsets, and reads them back, one byte at a time over the low byte of the FIFO's own data buses. It does not use an address for this. A shared write pointer and a separate read pointer each step through the four byte slots in a fixed cycle. The offsets go out as parallel values to the flag comparators, which sit outside this block.

A single dual-purpose control pin is sampled while reset is held. If it is low during reset, the block works in offset-load mode. In that mode, driving the pin low turns FIFO write and read accesses into offset accesses. If it is high during reset, the block works in dual-enable mode. In that mode the pin acts as an active-high second write enable, and the offsets stay at their defaults. The block also produces the qualified FIFO write and read strobes, so that an offset access and a FIFO access never happen in the same cycle.

Top module: `offs_regfile`

## Requirements
- R1: Synchronous reset (active-low) loads the almost-empty offset with AE_DEF and the almost-full offset with AF_DEF. It clears the readback byte to zero and returns both byte pointers to slot 0.
- R2: The mode is captured on each write-clock edge while reset is low. The control pin low selects offset-load mode and `load_mode_o` reads 1. The pin high selects dual-enable mode and `load_mode_o` reads 0. In dual-enable mode the offsets never leave their defaults.
- R3: Byte loads go through the slots in this order: slot 0 is the almost-empty low byte, slot 1 is the almost-empty high byte, slot 2 is the almost-full low byte and slot 3 is the almost-full high byte. After slot 3 the pointer wraps to slot 0.
- R4: A byte is loaded from `wdata_i` on a write-clock edge only in offset-load mode, with the control pin low and `wen1_n_i` low. Any other combination leaves both offsets unchanged.
- R5: The load pointer keeps its position while the control pin is high, so loads may be spread over separate bursts.
- R6: In offset-load mode, with the control pin low and both read enables low, a read-clock edge places the byte of the current read slot on `rdata_o` and advances the read pointer in the same slot order as R3. Otherwise `rdata_o` holds its value.
- R7: High-byte bits at or above position AW-8 are dropped on load and read back as zero.
- R8: `fifo_wr_o` is high exactly when reset is released, `wen1_n_i` is low and the control pin is high. This rule applies in both modes. A FIFO write never changes an offset.
- R9: `fifo_rd_o` is high exactly when reset is released and both read enables are low, unless the block is in offset-load mode with the control pin low. A FIFO read never changes `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_n_i | input | 1 | Dual-purpose pin: active-low offset access, or second write enable |
| wen1_n_i | input | 1 | Active-low first write enable |
| ren1_n_i | input | 1 | Active-low first read enable |
| ren2_n_i | input | 1 | Active-low second read enable |
| wdata_i | input | 8 | Low byte of the FIFO write data bus |
| rdata_o | output | 8 | Offset readback byte |
| ae_off_o | output | AW | Almost-empty offset to the comparator |
| af_off_o | output | AW | Almost-full offset to the comparator |
| load_mode_o | output | 1 | 1 when offset-load mode was captured at reset |
| fifo_wr_o | output | 1 | Qualified FIFO write strobe |
| fifo_rd_o | output | 1 | Qualified FIFO read strobe |

## Verification
A load pointer that slips, or that resets to the wrong place, sends the very next byte into the wrong slot. That error shows on `ae_off_o` or `af_off_o` one write-clock edge after the load. A bad read pointer or a bad mask shows on `rdata_o` one read-clock edge after the read access. A wrongly captured mode shows in several places. `load_mode_o` is wrong in the first cycle after reset. Offsets change in dual-enable mode, or fail to change in load mode. `fifo_wr_o` and `fifo_rd_o` are gated wrongly in the same cycle as the stimulus.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
   localparam int BYTE_W = 8;
   localparam int MIN_AW = 9;
   localparam int MAX_AW = 13;

   typedef enum logic [1:0] {
      SEL_AE_LO = 2'd0,
      SEL_AE_HI = 2'd1,
      SEL_AF_LO = 2'd2,
      SEL_AF_HI = 2'd3
   } ofs_sel_e;

   function automatic ofs_sel_e sel_next(input ofs_sel_e s);
      logic [1:0] n;
      n = s + 2'd1;
      return ofs_sel_e'(n);
   endfunction
endpackage

// File: rtl/ofs_mode.sv
module ofs_mode (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_pin_i,
   output logic load_mode_o
);
   // Captured on every edge while reset is held, frozen afterwards.
   always_ff @(posedge clk) begin
      if (!rst_n) load_mode_o <= ~cfg_pin_i;
   end
endmodule

// File: rtl/ofs_ptr.sv
module ofs_ptr
   import ofs_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     step_i,
   output ofs_sel_e sel_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      sel_o <= SEL_AE_LO;
      else if (step_i) sel_o <= sel_next(sel_o);
   end
endmodule

// File: rtl/ofs_word.sv
module ofs_word
   import ofs_pkg::*;
#(
   parameter int AW  = 9,
   parameter int DEF = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [AW-1:0]     val_o,
   output logic [BYTE_W-1:0] lo_byte_o,
   output logic [BYTE_W-1:0] hi_byte_o
);
   localparam int HI_W = AW - BYTE_W;
   localparam logic [AW-1:0] DEF_V = AW'(DEF);

   logic [BYTE_W-1:0] lo_q;
   logic [HI_W-1:0]   hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= DEF_V[BYTE_W-1:0];
         hi_q <= DEF_V[AW-1:BYTE_W];
      end else begin
         if (wr_lo_i) lo_q <= byte_i;
         if (wr_hi_i) hi_q <= byte_i[HI_W-1:0];
      end
   end

   assign val_o     = {hi_q, lo_q};
   assign lo_byte_o = lo_q;
   assign hi_byte_o = {{(BYTE_W-HI_W){1'b0}}, hi_q};
endmodule

// File: rtl/offs_regfile.sv
module offs_regfile
   import ofs_pkg::*;
#(
   parameter  int DEPTH  = 512,
   parameter  int AE_DEF = 7,
   parameter  int AF_DEF = 9,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              ld_n_i,
   input  logic              wen1_n_i,
   input  logic              ren1_n_i,
   input  logic              ren2_n_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] rdata_o,
   output logic [AW-1:0]     ae_off_o,
   output logic [AW-1:0]     af_off_o,
   output logic              load_mode_o,
   output logic              fifo_wr_o,
   output logic              fifo_rd_o
);
   localparam int NWORD = 2;

   generate
      if (DEPTH != (1 << AW) || AW < MIN_AW || AW > MAX_AW) begin : g_bad_depth
         $error("DEPTH must be a power of two from 512 to 8192");
      end
      if (AE_DEF < 0 || AE_DEF >= DEPTH || AF_DEF < 0 || AF_DEF >= DEPTH) begin : g_bad_def
         $error("offset defaults must fit the address width");
      end
   endgenerate

   logic     load_mode;
   logic     wr_acc, rd_acc;
   ofs_sel_e wsel, rsel;

   logic [AW-1:0]     val_w [NWORD];
   logic [BYTE_W-1:0] lo_b  [NWORD];
   logic [BYTE_W-1:0] hi_b  [NWORD];
   logic [BYTE_W-1:0] rd_byte;

   ofs_mode u_mode (
      .clk        (wr_clk),
      .rst_n      (rst_n),
      .cfg_pin_i  (ld_n_i),
      .load_mode_o(load_mode)
   );

   assign wr_acc = rst_n & load_mode & ~ld_n_i & ~wen1_n_i;
   assign rd_acc = rst_n & load_mode & ~ld_n_i & ~ren1_n_i & ~ren2_n_i;

   ofs_ptr u_wptr (
      .clk   (wr_clk),
      .rst_n (rst_n),
      .step_i(wr_acc),
      .sel_o (wsel)
   );

   ofs_ptr u_rptr (
      .clk   (rd_clk),
      .rst_n (rst_n),
      .step_i(rd_acc),
      .sel_o (rsel)
   );

   generate
      for (genvar g = 0; g < NWORD; g++) begin : g_word
         localparam int       DEF_G = (g == 0) ? AE_DEF : AF_DEF;
         localparam ofs_sel_e LO_S  = (g == 0) ? SEL_AE_LO : SEL_AF_LO;
         localparam ofs_sel_e HI_S  = (g == 0) ? SEL_AE_HI : SEL_AF_HI;
         ofs_word #(.AW(AW), .DEF(DEF_G)) u_word (
            .clk      (wr_clk),
            .rst_n    (rst_n),
            .wr_lo_i  (wr_acc && (wsel == LO_S)),
            .wr_hi_i  (wr_acc && (wsel == HI_S)),
            .byte_i   (wdata_i),
            .val_o    (val_w[g]),
            .lo_byte_o(lo_b[g]),
            .hi_byte_o(hi_b[g])
         );
      end
   endgenerate

   always_comb begin
      case (rsel)
         SEL_AE_LO: rd_byte = lo_b[0];
         SEL_AE_HI: rd_byte = hi_b[0];
         SEL_AF_LO: rd_byte = lo_b[1];
         default:   rd_byte = hi_b[1];
      endcase
   end

   always_ff @(posedge rd_clk) begin
      if (!rst_n)      rdata_o <= '0;
      else if (rd_acc) rdata_o <= rd_byte;
   end

   assign ae_off_o    = val_w[0];
   assign af_off_o    = val_w[1];
   assign load_mode_o = load_mode;
   assign fifo_wr_o   = rst_n & ~wen1_n_i & ld_n_i;
   assign fifo_rd_o   = rst_n & ~ren1_n_i & ~ren2_n_i & ~(load_mode & ~ld_n_i);
endmodule

// File: rtl/offs_regfile_chk.sv
module offs_regfile_chk #(
   parameter  int DEPTH  = 512,
   parameter  int AE_DEF = 7,
   parameter  int AF_DEF = 9,
   localparam int AW     = $clog2(DEPTH)
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          rst_n,
   input logic          ld_n_i,
   input logic          wen1_n_i,
   input logic          ren1_n_i,
   input logic          ren2_n_i,
   input logic [7:0]    rdata_o,
   input logic [AW-1:0] ae_off_o,
   input logic [AW-1:0] af_off_o,
   input logic          load_mode_o,
   input logic          fifo_wr_o,
   input logic          fifo_rd_o
);
   logic was_rst;
   always_ff @(posedge wr_clk) was_rst <= ~rst_n;

   // R1: first edge after a reset cycle sees defaults and a cleared readback byte
   always @(posedge wr_clk) begin
      if (rst_n && was_rst) begin
         a_r1_reset_defaults: assert (ae_off_o == AW'(AE_DEF) && af_off_o == AW'(AF_DEF)
                                      && rdata_o == 8'h00);
      end
   end

   a_r2_dual_enable_defaults: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !load_mode_o |-> (ae_off_o == AW'(AE_DEF) && af_off_o == AW'(AF_DEF)));

   a_r4_no_load_no_change: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wen1_n_i || ld_n_i) |=> ($stable(ae_off_o) && $stable(af_off_o)));

   a_r6_readback_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (ren1_n_i || ren2_n_i || ld_n_i) |=> $stable(rdata_o));

   a_r8_fifo_write_keeps_offsets: assert property (@(posedge wr_clk) disable iff (!rst_n)
      fifo_wr_o |=> ($stable(ae_off_o) && $stable(af_off_o)));

   a_r9_fifo_read_keeps_byte: assert property (@(posedge rd_clk) disable iff (!rst_n)
      fifo_rd_o |=> $stable(rdata_o));
endmodule

bind offs_regfile offs_regfile_chk #(.DEPTH(DEPTH), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_chk (
   .wr_clk     (wr_clk),
   .rd_clk     (rd_clk),
   .rst_n      (rst_n),
   .ld_n_i     (ld_n_i),
   .wen1_n_i   (wen1_n_i),
   .ren1_n_i   (ren1_n_i),
   .ren2_n_i   (ren2_n_i),
   .rdata_o    (rdata_o),
   .ae_off_o   (ae_off_o),
   .af_off_o   (af_off_o),
   .load_mode_o(load_mode_o),
   .fifo_wr_o  (fifo_wr_o),
   .fifo_rd_o  (fifo_rd_o)
);

// File: tb/sim_offs_regfile.sv
module sim_offs_regfile;
   localparam int DEPTH  = 512;
   localparam int AE_DEF = 7;
   localparam int AF_DEF = 9;
   localparam int AW     = $clog2(DEPTH);
   localparam int HMASK  = (1 << (AW - 8)) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_n = 1'b0, wen1_n = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1;
   logic [7:0]    wdata = 8'h00;
   logic [7:0]    rdata;
   logic [AW-1:0] ae_off, af_off;
   logic          load_mode, fifo_wr, fifo_rd;

   int checks = 0;
   int errors = 0;

   // reference model state
   int m_ae, m_af, m_wp, m_rp, m_q, m_mode;

   always #5 clk = ~clk;

   offs_regfile #(.DEPTH(DEPTH), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u0 (
      .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .ld_n_i(ld_n),
      .wen1_n_i(wen1_n), .ren1_n_i(ren1_n), .ren2_n_i(ren2_n),
      .wdata_i(wdata), .rdata_o(rdata), .ae_off_o(ae_off), .af_off_o(af_off),
      .load_mode_o(load_mode), .fifo_wr_o(fifo_wr), .fifo_rd_o(fifo_rd)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int m_byte(input int s);
      case (s)
         0: return m_ae & 255;
         1: return m_ae >> 8;
         2: return m_af & 255;
         default: return m_af >> 8;
      endcase
   endfunction

   // one clock: drive at falling edge, check strobes, update model at rising edge,
   // compare registered outputs at the next falling edge
   task automatic step(input bit rst, input bit ld, input bit w1, input bit r1,
                       input bit r2, input logic [7:0] d);
      int rb;
      rst_n = ~rst; ld_n = ld; wen1_n = w1; ren1_n = r1; ren2_n = r2; wdata = d;
      #1;
      chk("R8 fifo write strobe", fifo_wr, (!rst && !w1 && ld) ? 1 : 0);
      chk("R9 fifo read strobe", fifo_rd,
          (!rst && !r1 && !r2 && !(m_mode == 1 && !ld)) ? 1 : 0);
      @(posedge clk);
      if (rst) begin
         m_mode = ld ? 0 : 1;
         m_ae = AE_DEF; m_af = AF_DEF; m_wp = 0; m_rp = 0; m_q = 0;
      end else begin
         if (m_mode == 1 && !ld && !r1 && !r2) begin
            rb = m_byte(m_rp);
            m_q = rb;
            m_rp = (m_rp + 1) % 4;
         end
         if (m_mode == 1 && !ld && !w1) begin
            case (m_wp)
               0: m_ae = (m_ae & ~255) | int'(d);
               1: m_ae = (m_ae & 255) | ((int'(d) & HMASK) << 8);
               2: m_af = (m_af & ~255) | int'(d);
               default: m_af = (m_af & 255) | ((int'(d) & HMASK) << 8);
            endcase
            m_wp = (m_wp + 1) % 4;
         end
      end
      @(negedge clk);
      chk("R3 almost-empty offset", ae_off, m_ae);
      chk("R3 almost-full offset", af_off, m_af);
      chk("R6 readback byte", rdata, m_q);
      chk("R2 mode", load_mode, m_mode);
   endtask

   initial begin
      m_mode = 0; m_ae = AE_DEF; m_af = AF_DEF; m_wp = 0; m_rp = 0; m_q = 0;
      @(negedge clk);
      // reset with pin low: offset-load mode
      for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 1, 8'h00);
      chk("R1 ae default", ae_off, AE_DEF);
      chk("R1 af default", af_off, AF_DEF);
      chk("R1 readback cleared", rdata, 0);
      chk("R2 load mode captured", load_mode, 1);

      // load four bytes in slot order, with a masked high byte
      step(0, 0, 0, 1, 1, 8'h34);
      step(0, 0, 0, 1, 1, 8'hFF);
      chk("R7 high bits dropped", ae_off, 'h134);
      step(0, 0, 0, 1, 1, 8'h56);
      step(0, 0, 0, 1, 1, 8'h02);
      chk("R3 slot order af", af_off, 'h056);
      step(0, 0, 0, 1, 1, 8'hAB);
      chk("R3 wrap to slot 0", ae_off, 'h1AB);

      // interrupted load: FIFO writes in between, pointer kept
      step(0, 1, 0, 1, 1, 8'h99);
      step(0, 1, 0, 1, 1, 8'h77);
      chk("R8 fifo write leaves offsets", ae_off, 'h1AB);
      step(0, 0, 0, 1, 1, 8'h00);
      chk("R5 pointer kept across break", ae_off, 'h0AB);

      // pin low but write enable high: nothing loaded
      step(0, 0, 1, 1, 1, 8'hEE);
      chk("R4 no load without enable", ae_off, 'h0AB);
      chk("R4 af untouched", af_off, 'h056);

      step(0, 0, 0, 1, 1, 8'h11);
      step(0, 0, 0, 1, 1, 8'hFF);
      chk("R7 af high masked", af_off, 'h111);

      // readback sequence with wrap
      step(0, 0, 1, 0, 0, 8'h00);
      chk("R6 read slot 0", rdata, 'hAB);
      step(0, 0, 1, 0, 1, 8'h00);
      chk("R6 hold on partial enable", rdata, 'hAB);
      step(0, 0, 1, 0, 0, 8'h00);
      chk("R6 read slot 1", rdata, 'h00);
      step(0, 1, 1, 0, 0, 8'h00);
      chk("R9 fifo read leaves byte", rdata, 'h00);
      step(0, 0, 1, 0, 0, 8'h00);
      chk("R6 read slot 2", rdata, 'h11);
      step(0, 0, 1, 0, 0, 8'h00);
      chk("R7 high byte reads masked", rdata, 'h01);
      step(0, 0, 1, 0, 0, 8'h00);
      chk("R6 read wraps", rdata, 'hAB);

      // reset with pin high: dual-enable mode
      step(1, 1, 1, 1, 1, 8'h00);
      step(1, 1, 1, 1, 1, 8'h00);
      chk("R2 dual-enable mode", load_mode, 0);
      step(0, 0, 0, 1, 1, 8'h55);
      chk("R2 offsets stay default", ae_off, AE_DEF);
      step(0, 0, 1, 0, 0, 8'h00);
      chk("R9 read passes in dual mode", rdata, 0);
      step(0, 1, 0, 0, 0, 8'h66);
      chk("R2 af stays default", af_off, AF_DEF);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule